// File: doc/BRIEF.md
# BCD Hundredths Calendar Clock

This block is a time-of-day and calendar core. It advances on a one-cycle enable pulse that arrives 100 times per second. It keeps hundredths, seconds, minutes, hours, day of week, date, month and year as packed BCD in eight bytes. All eight bytes are visible at once on a 64-bit snapshot output. Software or a serial front end loads a complete new time through a 64-bit load port.

The hours byte holds either a 24-hour value or a 12-hour value with a PM flag. The date rolls over at the real length of the current month, including February in leap years. The day-of-week byte also carries two control flags. One flag halts timekeeping. The other is a mask for an external reset pin, and it is brought out on its own output.

Top module: `bcd_calendar_clock`

Snapshot byte k is `snap_o[8k+7:8k]`. The bytes are: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day/control, 5 date, 6 month, 7 year.

The load port is a valid/ready stream input. `load_ready` is held at 1, so the block never applies back-pressure. A beat is accepted in every cycle where `load_valid` is 1, and it takes effect at the next clock edge.

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, the snapshot is 64'h0001_0131_0000_0000. That is year 00, month 01, date 01, day 1 with halt=1 and mask=1, and all time fields 00 in 24-hour mode.
- R2: An accepted load beat replaces all eight bytes at the next edge, with the unused bits cleared. The zero bits are: seconds bit 7, minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7:6, month bits 7:5. A tick in the same cycle as the load is dropped. `load_ready` is always 1.
- R3: Each tick while running adds one hundredth. Hundredths wrap from 99 to 00 and carry into seconds. Seconds and minutes each wrap from 59 to 00 and carry onward.
- R4: In 24-hour mode (hours bit 7 = 0, BCD hours in bits 5:0), hours count 00 to 23. The step from 23 to 00 advances the date and the day of week.
- R5: In 12-hour mode (hours bit 7 = 1, PM flag in bit 5, BCD hours in bits 4:0), the hours step from 11 to 12 inverts the PM flag, and 12 goes to 01. Only 11 PM to 12 AM advances the date.
- R6: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. February ends on 29 when the BCD year is a multiple of 4 (00 included), and on 28 otherwise.
- R7: Month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R8: The day of week (day bits 2:0) counts 1 to 7 and returns to 1 on every date advance.
- R9: While day bit 5 (halt) is 1, ticks change nothing. `halted_o` equals that bit.
- R10: `rst_pin_mask_o` equals day bit 4 and follows loads.
- R11: In a cycle with no tick and no load, the snapshot does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle advance pulse, 100 per second |
| load_valid | input | 1 | Load beat present |
| load_ready | output | 1 | Load beat accepted (always 1) |
| load_data | input | 64 | New register image, byte k = register k |
| snap_o | output | 64 | Current register image |
| halted_o | output | 1 | Timekeeping halted (day bit 5) |
| rst_pin_mask_o | output | 1 | Reset-pin mask flag (day bit 4) |

## Verification
The assertions check these properties on every cycle:
- A load beat appears masked in the next snapshot.
- The zero bits never read back as 1.
- The snapshot holds still when there is no tick, or when the clock is halted.
- A running tick always moves the snapshot.
- Seconds and day of week stay in range.

The calendar arithmetic can only be shown by the bench's scenarios, which are compared each cycle against a behavioural model. This covers month lengths, the leap-year rule, the 12-hour PM toggle, the date carry and the year wrap.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int CAL_BYTES = 8;
  localparam int CAL_W     = 8 * CAL_BYTES;
  localparam int TMR_UNITS = 3;  // hundredths, seconds, minutes

  // bits that may hold a 1 in each register byte; year is the top byte
  localparam logic [CAL_W-1:0] CAL_LOAD_MASK = {8'hFF, 8'h1F, 8'h3F, 8'h37,
                                                8'hBF, 8'h7F, 8'h7F, 8'hFF};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of 4 in BCD: even tens with ones 0/4/8, odd tens with ones 2/6
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_ctr.sv
module cal_bcd_ctr
  import cal_pkg::*;
#(
  parameter logic [7:0] FIRST = 8'h00,
  parameter logic [7:0] RST   = 8'h00,
  parameter logic [7:0] MASK  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       step,
  input  logic [7:0] last,
  output logic [7:0] val,
  output logic       wrap
);
  assign wrap = step && (val >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)    val <= RST;
    else if (ld)   val <= ld_val & MASK;
    else if (wrap) val <= FIRST;
    else if (step) val <= bcd_inc(val) & MASK;
  end
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       step,
  output logic [7:0] val,
  output logic       day_carry
);
  logic [1:0] tens;
  logic [5:0] hr_inc;
  logic [7:0] nxt;
  logic       carry;

  assign tens   = val[7] ? {1'b0, val[4]} : val[5:4];
  assign hr_inc = (val[3:0] >= 4'd9) ? {tens + 2'd1, 4'h0} : {tens, val[3:0] + 4'd1};

  always_comb begin
    nxt   = val;
    carry = 1'b0;
    if (val[7]) begin
      if (val[4:0] == 5'h11) begin
        nxt[4:0] = 5'h12;
        nxt[5]   = ~val[5];
        carry    = val[5];
      end else if (val[4:0] == 5'h12) begin
        nxt[4:0] = 5'h01;
      end else begin
        nxt[4:0] = hr_inc[4:0];
      end
    end else if (val[5:0] == 6'h23) begin
      nxt[5:0] = 6'h00;
      carry    = 1'b1;
    end else begin
      nxt[5:0] = hr_inc;
    end
  end

  assign day_carry = step & carry;

  always_ff @(posedge clk) begin
    if (!rst_n)    val <= 8'h00;
    else if (ld)   val <= ld_val & 8'hBF;
    else if (step) val <= nxt;
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_100hz,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [CAL_W-1:0] load_data,
  output logic [CAL_W-1:0] snap_o,
  output logic             halted_o,
  output logic             rst_pin_mask_o
);
  logic [7:0]         tmr_q [TMR_UNITS];
  logic [TMR_UNITS:0] chain;
  logic [7:0]         hr_q, day_q, date_q, mon_q, year_q;
  logic               day_carry, date_wrap, mon_wrap;

  assign load_ready = 1'b1;
  assign chain[0]   = tick_100hz & ~day_q[5] & ~load_valid;

  for (genvar g = 0; g < TMR_UNITS; g++) begin : g_tmr
    localparam logic [7:0] LAST = (g == 0) ? 8'h99 : 8'h59;
    localparam logic [7:0] MSK  = (g == 0) ? 8'hFF : 8'h7F;
    cal_bcd_ctr #(.FIRST(8'h00), .RST(8'h00), .MASK(MSK)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld(load_valid), .ld_val(load_data[8*g +: 8]),
      .step(chain[g]), .last(LAST), .val(tmr_q[g]), .wrap(chain[g+1])
    );
  end

  cal_hour_unit u_hour (
    .clk(clk), .rst_n(rst_n), .ld(load_valid), .ld_val(load_data[31:24]),
    .step(chain[TMR_UNITS]), .val(hr_q), .day_carry(day_carry)
  );

  cal_bcd_ctr #(.FIRST(8'h01), .RST(8'h01), .MASK(8'h3F)) u_date (
    .clk(clk), .rst_n(rst_n), .ld(load_valid), .ld_val(load_data[47:40]),
    .step(day_carry), .last(month_last(mon_q, year_q)), .val(date_q), .wrap(date_wrap)
  );

  cal_bcd_ctr #(.FIRST(8'h01), .RST(8'h01), .MASK(8'h1F)) u_month (
    .clk(clk), .rst_n(rst_n), .ld(load_valid), .ld_val(load_data[55:48]),
    .step(date_wrap), .last(8'h12), .val(mon_q), .wrap(mon_wrap)
  );

  // day-of-week plus halt (bit 5) and reset-pin mask (bit 4)
  always_ff @(posedge clk) begin
    if (!rst_n)              day_q <= 8'h31;
    else if (load_valid)     day_q <= load_data[39:32] & 8'h37;
    else if (day_carry)      day_q[2:0] <= (day_q[2:0] >= 3'd7) ? 3'd1 : day_q[2:0] + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          year_q <= 8'h00;
    else if (load_valid) year_q <= load_data[63:56];
    else if (mon_wrap)   year_q <= (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
  end

  assign snap_o         = {year_q, mon_q, date_q, day_q, hr_q, tmr_q[2], tmr_q[1], tmr_q[0]};
  assign halted_o       = day_q[5];
  assign rst_pin_mask_o = day_q[4];
endmodule

// File: rtl/bcd_calendar_clock_chk.sv
module bcd_calendar_clock_chk
  import cal_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_100hz,
  input logic             load_valid,
  input logic [CAL_W-1:0] load_data,
  input logic [CAL_W-1:0] snap_o,
  input logic             halted_o
);
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> snap_o == ($past(load_data) & CAL_LOAD_MASK)); // R2
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_o & ~CAL_LOAD_MASK) == '0); // R2
  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_100hz && !load_valid && !halted_o) |=> snap_o != $past(snap_o)); // R3
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_o[15:8] <= 8'h59); // R3
  AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_o[34:32] != 3'd0); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !load_valid) |=> $stable(snap_o)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_100hz && !load_valid) |=> $stable(snap_o)); // R11
endmodule

bind bcd_calendar_clock bcd_calendar_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .load_valid(load_valid),
  .load_data(load_data), .snap_o(snap_o), .halted_o(halted_o)
);

// File: tb/bcd_calendar_clock_tb_top.sv
module bcd_calendar_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        lv = 1'b0;
  logic [63:0] ld = '0;
  logic        lrdy, halted, rmask;
  logic [63:0] snap;
  int          vecs = 0, fails = 0;
  string       tag = "R1";

  always #10 clk = ~clk;

  bcd_calendar_clock dut_i (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick), .load_valid(lv), .load_ready(lrdy),
    .load_data(ld), .snap_o(snap), .halted_o(halted), .rst_pin_mask_o(rmask)
  );

  // behavioural reference state
  int m_hu, m_se, m_mi, m_hr, m_pm, m_m12, m_dy, m_dt, m_mo, m_yr, m_stop, m_mask;

  function automatic logic [7:0] b8(int x);
    return {4'(x / 10), 4'(x % 10)};
  endfunction
  function automatic int ib(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [63:0] mk(int yr, int mo, int dt, int dy, int stp, int msk,
                                     int m12, int pm, int hr, int mi, int se, int hu);
    logic [7:0] h;
    logic [7:0] d;
    h = m12 != 0 ? {1'b1, 1'b0, pm[0], b8(hr)[4:0]} : {2'b00, b8(hr)[5:0]};
    d = {2'b00, stp[0], msk[0], 1'b0, dy[2:0]};
    return {b8(yr), b8(mo), b8(dt), d, h, b8(mi), b8(se), b8(hu)};
  endfunction
  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic date_adv();
    m_dy = (m_dy == 7) ? 1 : m_dy + 1;
    m_dt++;
    if (m_dt > mdays(m_mo, m_yr)) begin
      m_dt = 1; m_mo++;
      if (m_mo == 13) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
    end
  endtask

  task automatic adv();
    m_hu++;
    if (m_hu < 100) return;
    m_hu = 0; m_se++;
    if (m_se < 60) return;
    m_se = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0;
    if (m_m12 != 0) begin
      if (m_hr == 11) begin m_hr = 12; m_pm ^= 1; if (m_pm == 0) date_adv(); end
      else if (m_hr == 12) m_hr = 1;
      else m_hr++;
    end else begin
      m_hr++;
      if (m_hr == 24) begin m_hr = 0; date_adv(); end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hu = 0; m_se = 0; m_mi = 0; m_hr = 0; m_pm = 0; m_m12 = 0;
      m_dy = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_stop = 1; m_mask = 1;
    end else if (lv) begin
      m_hu = ib(ld[7:0]); m_se = ib({1'b0, ld[14:8]}); m_mi = ib({1'b0, ld[22:16]});
      m_m12 = int'(ld[31]);
      m_pm  = ld[31] ? int'(ld[29]) : 0;
      m_hr  = ld[31] ? ib({3'b0, ld[28:24]}) : ib({2'b0, ld[29:24]});
      m_stop = int'(ld[37]); m_mask = int'(ld[36]); m_dy = int'(ld[34:32]);
      m_dt = ib({2'b0, ld[45:40]}); m_mo = ib({3'b0, ld[52:48]}); m_yr = ib(ld[63:56]);
    end else if (tick && m_stop == 0) begin
      adv();
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    logic [63:0] exp_v;
    exp_v = mk(m_yr, m_mo, m_dt, m_dy, m_stop, m_mask, m_m12, m_pm, m_hr, m_mi, m_se, m_hu);
    vecs++;
    if (snap !== exp_v) begin
      fails++; $display("FAIL %s: snap=%h expected %h", tag, snap, exp_v);
    end
    if (halted !== m_stop[0]) begin
      fails++; $display("FAIL R9 %s: halted_o=%b expected %b", tag, halted, m_stop[0]);
    end
    if (rmask !== m_mask[0]) begin
      fails++; $display("FAIL R10 %s: rst_pin_mask_o=%b expected %b", tag, rmask, m_mask[0]);
    end
    if (lrdy !== 1'b1) begin
      fails++; $display("FAIL R2: load_ready=%b expected 1", lrdy);
    end
  end

  task automatic cyc(int n, bit t);
    repeat (n) begin @(negedge clk); tick = t; lv = 1'b0; end
  endtask
  task automatic load(logic [63:0] d, bit t);
    @(negedge clk); ld = d; lv = 1'b1; tick = t;
    @(negedge clk); lv = 1'b0; tick = 1'b0;
  endtask
  task automatic edge_case(string t, logic [63:0] d);
    tag = t; load(d, 1'b0); cyc(1, 1'b1); cyc(2, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    tag = "R1"; cyc(3, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc(2, 1'b0);
    tag = "R9"; cyc(6, 1'b1);
    tag = "R2"; load(mk(99, 12, 31, 7, 0, 0, 0, 0, 23, 59, 59, 99) | ~64'hFF1F3F37BF7F7FFF, 1'b1);
    tag = "R7"; cyc(1, 1'b1); cyc(2, 1'b0);
    edge_case("R4", mk(5, 3, 14, 3, 0, 1, 0, 0, 23, 59, 59, 99));
    edge_case("R4", mk(5, 3, 14, 3, 0, 0, 0, 0, 19, 59, 59, 99));
    edge_case("R8", mk(5, 3, 14, 7, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(23, 2, 28, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(24, 2, 28, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(24, 2, 29, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(0, 2, 28, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(1, 2, 28, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(23, 4, 30, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(23, 11, 30, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R6", mk(23, 1, 31, 2, 0, 0, 0, 0, 23, 59, 59, 99));
    edge_case("R5", mk(23, 6, 10, 4, 0, 0, 1, 0, 11, 59, 59, 99));
    edge_case("R5", mk(23, 6, 10, 4, 0, 0, 1, 1, 12, 59, 59, 99));
    edge_case("R5", mk(23, 6, 30, 4, 0, 0, 1, 1, 11, 59, 59, 99));
    edge_case("R5", mk(23, 6, 10, 4, 0, 0, 1, 0, 9, 59, 59, 99));
    tag = "R2"; load(mk(10, 10, 10, 5, 0, 0, 0, 0, 10, 10, 10, 10), 1'b1); cyc(1, 1'b0);
    tag = "R10"; load(mk(10, 10, 10, 5, 0, 1, 0, 0, 10, 10, 10, 10), 1'b0); cyc(3, 1'b0);
    tag = "R11"; cyc(10, 1'b0);
    tag = "R9"; load(mk(10, 10, 10, 5, 1, 0, 0, 0, 10, 10, 10, 10), 1'b0); cyc(8, 1'b1);
    tag = "R3"; load(mk(44, 8, 20, 6, 0, 0, 0, 0, 22, 58, 58, 0), 1'b0);
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk); lv = 1'b0; tick = 1'($urandom_range(0, 3) != 0);
    end
    tag = "R4"; load(mk(44, 8, 31, 6, 0, 0, 0, 0, 23, 59, 0, 0), 1'b0); cyc(6100, 1'b1);
    cyc(2, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule